// File: doc/BRIEF.md
# YCbCr 4:2:2 Pixel Port Demultiplexer

This block receives 4:2:2 component video from a parallel pixel port and rebuilds co-sited pixels. Each output pixel has a luma sample and a shared chroma pair. The port runs in one of two layouts:

- **Narrow layout:** a single byte lane carries chroma and luma interleaved, and one byte is taken on every clock edge.
- **Wide layout:** the low byte carries luma and the high byte carries alternating chroma, and a word is taken on every other edge.

Each chroma-blue / luma / chroma-red / luma quartet gives two pixels, and both of them reuse the same chroma pair. Bytes outside the legal video range are clamped, and a sticky flag records that clamping took place. While the active-low blank input is low, the port contents are discarded and black is produced in their place.

A start-of-line strobe realigns the internal slot tracking. The first byte or word after the strobe is always treated as chroma-blue. The strobe is also the only moment at which a new layout selection takes effect.

The output is a valid/ready stream. The pixel port itself can never be stalled, so back-pressure is limited:

- While `out_ready` is low, a presented pixel and `out_valid` are held steady.
- If a newer pixel is completed before the held one is taken, the newer pixel replaces it.
- A consumer that must see every pixel has to keep `out_ready` high whenever the port is carrying traffic.

Top module: `ycc422_demux`

## Requirements
- R1: While `rst` is high and after its release, `out_valid` is 0 and `clamp_seen` is 0. The active layout is narrow until a start-of-line strobe loads another.
- R2: In the narrow layout, the four bytes that follow a strobe on `pix_in[7:0]` are taken in the order Cb, Y0, Cr, Y1, one per edge, and the pattern then repeats. They produce the pixel (Y0,Cb,Cr) followed by the pixel (Y1,Cb,Cr).
- R3: In the wide layout (`cfg_wide`=1 at the strobe), words are taken only on the 1st, 3rd, 5th and following edges after the strobe, and the words on the other edges are ignored. The low byte is luma. The high byte alternates Cb then Cr. A word pair {Cb,Y0},{Cr,Y1} produces (Y0,Cb,Cr) followed by (Y1,Cb,Cr).
- R4: An edge with `sol`=1 captures nothing and discards any partly received quartet. The next captured byte or word is Cb.
- R5: `cfg_wide` is sampled only on edges where `sol`=1. Changing it at any other time has no effect on the layout.
- R6: Luma values below 16 become 16 and luma values above 235 become 235. Chroma values below 16 become 16 and chroma values above 240 become 240. The values 16, 235 and 240 pass through unchanged.
- R7: `clamp_seen` rises after a captured, unblanked sample that lies outside its legal range, and it stays at 1 until reset. Legal samples and blanked samples never set it.
- R8: A sample captured while `blank_n`=0 is replaced by 16 in a luma slot and by 128 in a chroma slot. Pixels are still produced at the normal rate.
- R9: In the narrow layout, the first pixel of a quartet is presented in the cycle after the edge that captures Cr, and the second pixel in the cycle after that.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` stays at 1. With no newer pixel completed, `out_y`, `out_cb` and `out_cr` are also unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-port clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wide | input | 1 | Layout request: 0 narrow, 1 wide. Loaded at a strobe |
| sol | input | 1 | Start-of-line strobe. The slot after it is Cb |
| blank_n | input | 1 | Active-low blank: low substitutes black samples |
| pix_in | input | 16 | Pixel port. [7:0] is the narrow lane or luma; [15:8] is wide chroma |
| out_valid | output | 1 | A pixel is presented |
| out_ready | input | 1 | Consumer accepts the presented pixel |
| out_y | output | 8 | Pixel luma |
| out_cb | output | 8 | Pixel blue-difference chroma |
| out_cr | output | 8 | Pixel red-difference chroma |
| clamp_seen | output | 1 | Sticky flag: an out-of-range sample was clamped |

## Verification
The narrow layout is exercised in four ways:

- **Two quartets with distinct bytes:** a swapped slot or a lost chroma pair shows up as a wrong field.
- **A quartet interrupted by a strobe:** this separates true realignment from a free-running phase.
- **Blanked bytes of value 255:** these show that substitution happens and that blanked data never reaches the clamp flag.
- **Exact boundary bytes followed by bytes just outside the range:** these tell clamping apart from pass-through.

The wide layout is fed garbage words on its skipped edges, so a capture on the wrong edge corrupts the result. A layout request that is raised without a strobe shows that the selection is loaded only at a line start. A stalled consumer shows that the held pixel is kept stable and is then overwritten.

// File: rtl/ycc_demux_pkg.sv
package ycc_demux_pkg;
  typedef enum logic [1:0] {
    SLOT_CB = 2'd0,
    SLOT_Y0 = 2'd1,
    SLOT_CR = 2'd2,
    SLOT_Y1 = 2'd3
  } slot_e;

  localparam int LUMA_LO     = 16;
  localparam int LUMA_HI     = 235;
  localparam int CHROMA_LO   = 16;
  localparam int CHROMA_HI   = 240;
  localparam int LUMA_BLACK  = 16;
  localparam int CHROMA_ZERO = 128;
endpackage

// File: rtl/ycc_range_clamp.sv
module ycc_range_clamp #(
  parameter int DW = 8,
  parameter int LO = 16,
  parameter int HI = 235
) (
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] fixed,
  output logic          beyond
);
  localparam logic [DW-1:0] LO_V = DW'(LO);
  localparam logic [DW-1:0] HI_V = DW'(HI);

  always_comb begin
    if (raw < LO_V) begin
      fixed  = LO_V;
      beyond = 1'b1;
    end else if (raw > HI_V) begin
      fixed  = HI_V;
      beyond = 1'b1;
    end else begin
      fixed  = raw;
      beyond = 1'b0;
    end
  end
endmodule

// File: rtl/ycc_slot_tracker.sv
module ycc_slot_tracker
  import ycc_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sol,
  input  logic  cfg_wide,
  output logic  wide_q,
  output logic  cap_en,
  output slot_e slot
);
  logic [1:0] phase_q;
  logic       skip_q;   // wide layout: high on the edges that are not sampled
  logic       crsel_q;  // wide layout: next chroma word is Cr

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 2'd0;
      skip_q  <= 1'b0;
      crsel_q <= 1'b0;
      wide_q  <= 1'b0;
    end else if (sol) begin
      phase_q <= 2'd0;
      skip_q  <= 1'b0;
      crsel_q <= 1'b0;
      wide_q  <= cfg_wide;
    end else begin
      skip_q <= ~skip_q;
      if (cap_en) begin
        phase_q <= phase_q + 2'd1;
        crsel_q <= ~crsel_q;
      end
    end
  end

  always_comb begin
    cap_en = !sol && (wide_q ? !skip_q : 1'b1);
    if (wide_q) slot = crsel_q ? SLOT_CR : SLOT_CB;
    else        slot = slot_e'(phase_q);
  end
endmodule

// File: rtl/ycc_pixel_builder.sv
module ycc_pixel_builder
  import ycc_demux_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide,
  input  logic          cap_en,
  input  slot_e         slot,
  input  logic [DW-1:0] luma,
  input  logic [DW-1:0] chroma,
  output logic          emit,
  output logic [DW-1:0] px_y,
  output logic [DW-1:0] px_cb,
  output logic [DW-1:0] px_cr
);
  logic [DW-1:0] cb_q, y0_q, cr_q, y1_q;
  logic          pend_q;   // wide layout: second pixel of the pair still owed

  always_ff @(posedge clk) begin
    if (rst) begin
      cb_q   <= '0;
      y0_q   <= '0;
      cr_q   <= '0;
      y1_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= cap_en && wide && (slot == SLOT_CR);
      if (cap_en) begin
        unique case (slot)
          SLOT_CB: begin
            cb_q <= chroma;
            if (wide) y0_q <= luma;
          end
          SLOT_Y0: y0_q <= luma;
          SLOT_CR: begin
            cr_q <= chroma;
            if (wide) y1_q <= luma;
          end
          SLOT_Y1: ;
        endcase
      end
    end
  end

  always_comb begin
    emit  = 1'b0;
    px_y  = y1_q;
    px_cb = cb_q;
    px_cr = cr_q;
    if (pend_q) begin
      emit = 1'b1;
    end else if (cap_en && slot == SLOT_CR) begin
      emit  = 1'b1;
      px_y  = y0_q;
      px_cr = chroma;
    end else if (cap_en && slot == SLOT_Y1) begin
      emit  = 1'b1;
      px_y  = luma;
    end
  end
endmodule

// File: rtl/ycc422_demux.sv
module ycc422_demux
  import ycc_demux_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wide,
  input  logic          sol,
  input  logic          blank_n,
  input  logic [2*DW-1:0] pix_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cb,
  output logic [DW-1:0] out_cr,
  output logic          clamp_seen
);
  localparam int LANES = 3;  // 0: low byte as luma, 1: low byte as chroma, 2: high byte as chroma

  logic          wide_q, cap_en;
  slot_e         slot;
  logic [DW-1:0] raw    [LANES];
  logic [DW-1:0] fixed  [LANES];
  logic          beyond [LANES];
  logic [DW-1:0] luma_v, chroma_v;
  logic          emit, oor_hit;
  logic [DW-1:0] px_y, px_cb, px_cr;

  ycc_slot_tracker u_track (
    .clk(clk), .rst(rst), .sol(sol), .cfg_wide(cfg_wide),
    .wide_q(wide_q), .cap_en(cap_en), .slot(slot)
  );

  assign raw[0] = pix_in[DW-1:0];
  assign raw[1] = pix_in[DW-1:0];
  assign raw[2] = pix_in[2*DW-1:DW];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_luma
      ycc_range_clamp #(.DW(DW), .LO(LUMA_LO), .HI(LUMA_HI)) u_clamp (
        .raw(raw[g]), .fixed(fixed[g]), .beyond(beyond[g]));
    end else begin : g_chroma
      ycc_range_clamp #(.DW(DW), .LO(CHROMA_LO), .HI(CHROMA_HI)) u_clamp (
        .raw(raw[g]), .fixed(fixed[g]), .beyond(beyond[g]));
    end
  end

  always_comb begin
    luma_v   = blank_n ? fixed[0] : DW'(LUMA_BLACK);
    chroma_v = blank_n ? (wide_q ? fixed[2] : fixed[1]) : DW'(CHROMA_ZERO);
    if (wide_q)
      oor_hit = beyond[0] | beyond[2];
    else if (slot == SLOT_Y0 || slot == SLOT_Y1)
      oor_hit = beyond[0];
    else
      oor_hit = beyond[1];
    oor_hit = oor_hit && cap_en && blank_n;
  end

  ycc_pixel_builder #(.DW(DW)) u_build (
    .clk(clk), .rst(rst), .wide(wide_q), .cap_en(cap_en), .slot(slot),
    .luma(luma_v), .chroma(chroma_v),
    .emit(emit), .px_y(px_y), .px_cb(px_cb), .px_cr(px_cr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_y      <= '0;
      out_cb     <= '0;
      out_cr     <= '0;
      clamp_seen <= 1'b0;
    end else begin
      if (oor_hit) clamp_seen <= 1'b1;
      if (emit) begin
        out_valid <= 1'b1;
        out_y     <= px_y;
        out_cb    <= px_cb;
        out_cr    <= px_cr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ycc422_demux_chk.sv
module ycc422_demux_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_cb,
  input logic [DW-1:0] out_cr,
  input logic          clamp_seen,
  input logic          wide,
  input logic          cap
);
  import ycc_demux_pkg::*;

  // R10
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    clamp_seen |=> clamp_seen);

  // R6
  legal_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_y >= DW'(LUMA_LO) && out_y <= DW'(LUMA_HI) &&
                   out_cb >= DW'(CHROMA_LO) && out_cb <= DW'(CHROMA_HI) &&
                   out_cr >= DW'(CHROMA_LO) && out_cr <= DW'(CHROMA_HI)));

  // R3
  alt_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (wide && cap) |=> !cap);
endmodule

bind ycc422_demux ycc422_demux_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr), .clamp_seen(clamp_seen),
  .wide(wide_q), .cap(cap_en)
);

// File: tb/ycc422_demux_tb_top.sv
`timescale 1ns/1ps
module ycc422_demux_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wide = 1'b1;
  logic        sol = 1'b0;
  logic        blank_n = 1'b1;
  logic [15:0] pix_in = 16'h0;
  logic        out_valid, out_ready = 1'b1;
  logic [7:0]  out_y, out_cb, out_cr;
  logic        clamp_seen;

  always #10 clk = ~clk;

  ycc422_demux dut_i (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .sol(sol), .blank_n(blank_n),
    .pix_in(pix_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr), .clamp_seen(clamp_seen)
  );

  int checks = 0;
  int errors = 0;
  int n_got = 0;
  logic [7:0] gy [16];
  logic [7:0] gcb[16];
  logic [7:0] gcr[16];

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && n_got < 16) begin
      gy[n_got]  = out_y;
      gcb[n_got] = out_cb;
      gcr[n_got] = out_cr;
      n_got = n_got + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] d, input logic bn, input logic s);
    @(posedge clk);
    #2;
    pix_in  = d;
    blank_n = bn;
    sol     = s;
  endtask

  task automatic byte8(input logic [7:0] b);
    step({8'h00, b}, 1'b1, 1'b0);
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) step(16'h0, 1'b1, 1'b1);
  endtask

  task automatic expect_px(input string req, input int idx, input int y, input int cb, input int cr);
    chk(req, $sformatf("pixel %0d present", idx), int'(n_got > idx), 1);
    if (n_got > idx) begin
      chk(req, $sformatf("pixel %0d Y", idx), gy[idx], y);
      chk(req, $sformatf("pixel %0d Cb", idx), gcb[idx], cb);
      chk(req, $sformatf("pixel %0d Cr", idx), gcr[idx], cr);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // R1 and R5: reset state, then narrow layout despite cfg_wide=1
  task automatic t_reset_default();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid in reset", out_valid, 0);
    chk("R1", "flag in reset", clamp_seen, 0);
    @(posedge clk);
    #2;
    rst    = 1'b0;
    pix_in = 16'h0050;
    n_got  = 0;
    byte8(8'h40); byte8(8'h60); byte8(8'h41);
    flush(3);
    chk("R5", "pixel count", n_got, 2);
    expect_px("R5", 0, 8'h40, 8'h50, 8'h60);
    expect_px("R5", 1, 8'h41, 8'h50, 8'h60);
    chk("R1", "flag after legal data", clamp_seen, 0);
  endtask

  // R3: wide layout, garbage on skipped edges
  task automatic t_wide();
    flush(2);
    n_got = 0;
    step(16'h5A30, 1, 0); step(16'h0101, 1, 0);
    step(16'h6B31, 1, 0); step(16'hFEFE, 1, 0);
    step(16'h7C90, 1, 0); step(16'h0303, 1, 0);
    step(16'h2DA1, 1, 0); step(16'hFFFF, 1, 0);
    flush(3);
    chk("R3", "pixel count", n_got, 4);
    expect_px("R3", 0, 8'h30, 8'h5A, 8'h6B);
    expect_px("R3", 1, 8'h31, 8'h5A, 8'h6B);
    expect_px("R3", 2, 8'h90, 8'h7C, 8'h2D);
    expect_px("R3", 3, 8'hA1, 8'h7C, 8'h2D);
    chk("R7", "skipped garbage not clamped", clamp_seen, 0);
    cfg_wide = 1'b0;
    flush(2);
  endtask

  // R2 and R9: narrow layout, two quartets, presentation timing
  task automatic t_narrow();
    n_got = 0;
    byte8(8'h50); byte8(8'h40); byte8(8'h60); byte8(8'h41);
    @(negedge clk);
    chk("R9", "first pixel valid after Cr edge", out_valid, 1);
    chk("R9", "first pixel Y", out_y, 8'h40);
    byte8(8'h90);
    @(negedge clk);
    chk("R9", "second pixel Y next cycle", out_y, 8'h41);
    byte8(8'h80); byte8(8'h30); byte8(8'hA0);
    flush(3);
    chk("R2", "pixel count", n_got, 4);
    expect_px("R2", 0, 8'h40, 8'h50, 8'h60);
    expect_px("R2", 1, 8'h41, 8'h50, 8'h60);
    expect_px("R2", 2, 8'h80, 8'h90, 8'h30);
    expect_px("R2", 3, 8'hA0, 8'h90, 8'h30);
  endtask

  // R4: strobe inside a quartet
  task automatic t_resync();
    n_got = 0;
    byte8(8'h70); byte8(8'h71);
    step(16'h0, 1, 1);
    byte8(8'h55); byte8(8'h66); byte8(8'h77); byte8(8'h68);
    flush(3);
    chk("R4", "pixel count", n_got, 2);
    expect_px("R4", 0, 8'h66, 8'h55, 8'h77);
    expect_px("R4", 1, 8'h68, 8'h55, 8'h77);
  endtask

  // R8: blanked quartet of 0xFF
  task automatic t_blank();
    n_got = 0;
    for (int i = 0; i < 4; i++) step(16'h00FF, 1'b0, 1'b0);
    flush(3);
    chk("R8", "pixel count", n_got, 2);
    expect_px("R8", 0, 16, 128, 128);
    expect_px("R8", 1, 16, 128, 128);
    chk("R7", "blanked data not flagged", clamp_seen, 0);
  endtask

  // R10: stalled consumer
  task automatic t_stall();
    n_got = 0;
    out_ready = 1'b0;
    byte8(8'h52); byte8(8'h42); byte8(8'h62); byte8(8'h43);
    flush(2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", "valid held", out_valid, 1);
      chk("R10", "data held", out_y, 8'h43);
    end
    chk("R10", "nothing taken while stalled", n_got, 0);
    @(posedge clk);
    #2;
    out_ready = 1'b1;
    flush(2);
    chk("R10", "one pixel after release", n_got, 1);
    expect_px("R10", 0, 8'h43, 8'h52, 8'h62);
    @(negedge clk);
    chk("R10", "valid dropped after take", out_valid, 0);
  endtask

  // R6 and R7: boundary then clamped values
  task automatic t_clamp();
    n_got = 0;
    byte8(8'd16); byte8(8'd235); byte8(8'd240); byte8(8'd16);
    flush(3);
    expect_px("R6", 0, 235, 16, 240);
    expect_px("R6", 1, 16, 16, 240);
    chk("R7", "flag after boundary values", clamp_seen, 0);
    n_got = 0;
    byte8(8'd241); byte8(8'd236); byte8(8'd15); byte8(8'd0);
    flush(3);
    expect_px("R6", 0, 235, 240, 16);
    expect_px("R6", 1, 16, 240, 16);
    chk("R7", "flag after clamp", clamp_seen, 1);
    byte8(8'h50); byte8(8'h40); byte8(8'h60); byte8(8'h41);
    flush(3);
    chk("R7", "flag sticky", clamp_seen, 1);
  endtask

  initial begin
    t_reset_default();
    t_wide();
    t_narrow();
    t_resync();
    t_blank();
    t_stall();
    t_clamp();
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule